// File: doc/BRIEF.md
# Sticky Interrupt Status and Mask Register Set

This block keeps a vector of sticky interrupt-pending bits and a matching vector of mask bits behind a small 32-bit register bus. A hardware event pulse raises a pending bit. Software clears that bit by writing a one to it. The mask itself cannot be written directly. Software changes it only through two write-only strobe registers: one opens bits and the other closes them. The block drives a single level interrupt line that is high while any pending bit is unmasked.

Each bit is a small four-state machine. The state holds the pair (mask, pending) as one of these:
- `ST_MASK_IDLE`: masked, nothing pending. This is the reset state.
- `ST_MASK_HELD`: masked, pending.
- `ST_OPEN_IDLE`: unmasked, nothing pending.
- `ST_OPEN_FIRE`: unmasked, pending. This state drives the interrupt.

The transitions are:
- **raise**: an event moves the bit from idle to held, or from idle to fire.
- **ack**: a write-one-to-clear with no event in the same cycle moves the bit from held to idle, or from fire to idle.
- **open**: an enable strobe moves the bit from a mask state to the matching open state.
- **close**: a disable strobe moves the bit from an open state to the matching mask state.

A raise and an open can happen in the same cycle, for example `ST_MASK_IDLE` straight to `ST_OPEN_FIRE`. The same holds for a raise and a close.

The register map uses byte offsets and word index = `addr[3:2]`:

| Offset | Register | Access |
|--------|----------|--------|
| 0x0 | status | read, write-one-to-clear |
| 0x4 | mask | read only |
| 0x8 | enable | write only |
| 0xC | disable | write only |

Top module: `irqsm_regs`

## Requirements
- R1: After reset every status bit is 0, every mask bit is 1 (the mask reads all ones) and `irq_o` is 0.
- R2: A one on `evt_i[k]` in a clock cycle sets status bit k, and the bit stays set after the event input returns to 0.
- R3: A write to offset 0x0 clears each status bit whose write-data bit is 1; bits written 0 keep their value.
- R4: When an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: A write to offset 0x4 (mask) changes no mask bit.
- R6: A write to offset 0x8 (enable) clears each mask bit whose write-data bit is 1 and leaves the others unchanged.
- R7: A write to offset 0xC (disable) sets each mask bit whose write-data bit is 1 and leaves the others unchanged.
- R8: Reads of offsets 0x8 and 0xC return 0, and these registers store no value.
- R9: `irq_o` equals the OR over all bits of (status AND NOT mask). It is registered, so it changes at the clock edge that samples the causing write or event and never before that edge.
- R10: An access whose address has a nonzero `addr[1:0]` is invalid: a write to it changes nothing and a read returns 0.
- R11: `rdata_o` is combinational from `addr_i`. Offset 0x0 returns status and offset 0x4 returns mask, in bits N_SRC-1:0, with zeros above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Byte address of the access |
| we_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i` |
| evt_i | input | N_SRC | Per-bit event pulses that set status |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest case to reach from the ports is a write-one-to-clear that lands in the same cycle as an event on the same bit. This must also happen while the bit is unmasked, so that the interrupt line shows whether the bit survived. Directed steps open the mask, raise the bit, and then issue the collision on purpose. The random phase also copies part of the write data into the event vector on status writes, so that collisions occur on many bit positions. Misaligned writes to the strobe offsets are mixed in to show they leave the mask untouched.

// File: rtl/irqsm_pkg.sv
`timescale 1ns/1ps
package irqsm_pkg;
    // Per-bit state encoded as {mask, pending}
    typedef enum logic [1:0] {
        ST_OPEN_IDLE = 2'b00,
        ST_OPEN_FIRE = 2'b01,
        ST_MASK_IDLE = 2'b10,
        ST_MASK_HELD = 2'b11
    } bit_state_e;

    // Word index addr[3:2]
    typedef enum logic [1:0] {
        REG_STATUS  = 2'd0,
        REG_MASK    = 2'd1,
        REG_ENABLE  = 2'd2,
        REG_DISABLE = 2'd3
    } reg_sel_e;

    localparam int WORD_LSB  = 2;
    localparam int MAP_BITS  = 4;
endpackage

// File: rtl/irqsm_decode.sv
`timescale 1ns/1ps
module irqsm_decode
    import irqsm_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int N_SRC  = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [N_SRC-1:0]  clr_o,
    output logic [N_SRC-1:0]  en_o,
    output logic [N_SRC-1:0]  dis_o,
    output reg_sel_e          sel_o,
    output logic              ok_o
);
    localparam int HI_W = ADDR_W - MAP_BITS;

    logic hi_ok;
    logic aligned;
    logic wr_ok;

    generate
        if (HI_W > 0) begin : g_hi
            assign hi_ok = (addr_i[ADDR_W-1:MAP_BITS] == '0);
        end else begin : g_nohi
            assign hi_ok = 1'b1;
        end
    endgenerate

    assign aligned = (addr_i[WORD_LSB-1:0] == '0);
    assign ok_o    = aligned && hi_ok;
    assign sel_o   = reg_sel_e'(addr_i[MAP_BITS-1:WORD_LSB]);
    assign wr_ok   = we_i && ok_o;

    always_comb begin
        clr_o = '0;
        en_o  = '0;
        dis_o = '0;
        if (wr_ok) begin
            unique case (sel_o)
                REG_STATUS:  clr_o = wdata_i[N_SRC-1:0];
                REG_MASK:    ;
                REG_ENABLE:  en_o  = wdata_i[N_SRC-1:0];
                REG_DISABLE: dis_o = wdata_i[N_SRC-1:0];
                default:     ;
            endcase
        end
    end
endmodule

// File: rtl/irqsm_bit_fsm.sv
`timescale 1ns/1ps
module irqsm_bit_fsm
    import irqsm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic en_i,
    input  logic dis_i,
    output logic stat_o,
    output logic mask_o,
    output logic fire_o
);
    bit_state_e state_q, state_d;
    logic       fire_q;
    logic       keep;
    logic       opening;

    assign keep    = set_i || !clr_i;
    assign opening = en_i && !dis_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_MASK_IDLE:
                if (opening) state_d = set_i ? ST_OPEN_FIRE : ST_OPEN_IDLE;
                else         state_d = set_i ? ST_MASK_HELD : ST_MASK_IDLE;
            ST_MASK_HELD:
                if (opening) state_d = keep ? ST_OPEN_FIRE : ST_OPEN_IDLE;
                else         state_d = keep ? ST_MASK_HELD : ST_MASK_IDLE;
            ST_OPEN_IDLE:
                if (dis_i)   state_d = set_i ? ST_MASK_HELD : ST_MASK_IDLE;
                else         state_d = set_i ? ST_OPEN_FIRE : ST_OPEN_IDLE;
            ST_OPEN_FIRE:
                if (dis_i)   state_d = keep ? ST_MASK_HELD : ST_MASK_IDLE;
                else         state_d = keep ? ST_OPEN_FIRE : ST_OPEN_IDLE;
            default:         state_d = ST_MASK_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_MASK_IDLE;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fire_q <= 1'b0;
        else        fire_q <= (state_d == ST_OPEN_FIRE);
    end

    assign stat_o = state_q[0];
    assign mask_o = state_q[1];
    assign fire_o = fire_q;

    // R2
    raise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> stat_o);
    // R2
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o && !clr_i) |=> stat_o);
    // R3
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !stat_o);
    // R6
    open_clears_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !dis_i) |=> !mask_o);
    // R7
    close_sets_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dis_i |=> mask_o);
    // R9
    fire_tracks_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o == (stat_o && !mask_o));
endmodule

// File: rtl/irqsm_rdmux.sv
`timescale 1ns/1ps
module irqsm_rdmux
    import irqsm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int N_SRC  = 32
) (
    input  reg_sel_e          sel_i,
    input  logic              ok_i,
    input  logic [N_SRC-1:0]  stat_i,
    input  logic [N_SRC-1:0]  mask_i,
    output logic [DATA_W-1:0] rdata_o
);
    always_comb begin
        rdata_o = '0;
        if (ok_i) begin
            unique case (sel_i)
                REG_STATUS:  rdata_o[N_SRC-1:0] = stat_i;
                REG_MASK:    rdata_o[N_SRC-1:0] = mask_i;
                REG_ENABLE:  ;
                REG_DISABLE: ;
                default:     ;
            endcase
        end
    end
endmodule

// File: rtl/irqsm_regs.sv
`timescale 1ns/1ps
module irqsm_regs
    import irqsm_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int N_SRC  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [N_SRC-1:0]  evt_i,
    output logic              irq_o
);
    logic [N_SRC-1:0] clr_v, en_v, dis_v;
    logic [N_SRC-1:0] stat_v, mask_v, fire_v;
    reg_sel_e         sel;
    logic             ok;

    irqsm_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SRC(N_SRC)) u_dec (
        .addr_i (addr_i),
        .we_i   (we_i),
        .wdata_i(wdata_i),
        .clr_o  (clr_v),
        .en_o   (en_v),
        .dis_o  (dis_v),
        .sel_o  (sel),
        .ok_o   (ok)
    );

    generate
        for (genvar k = 0; k < N_SRC; k++) begin : g_bit
            irqsm_bit_fsm u_bit (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (evt_i[k]),
                .clr_i (clr_v[k]),
                .en_i  (en_v[k]),
                .dis_i (dis_v[k]),
                .stat_o(stat_v[k]),
                .mask_o(mask_v[k]),
                .fire_o(fire_v[k])
            );
        end
    endgenerate

    irqsm_rdmux #(.DATA_W(DATA_W), .N_SRC(N_SRC)) u_rd (
        .sel_i  (sel),
        .ok_i   (ok),
        .stat_i (stat_v),
        .mask_i (mask_v),
        .rdata_o(rdata_o)
    );

    assign irq_o = |fire_v;

    // R9
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |(stat_v & ~mask_v));
    // R5
    mask_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == ADDR_W'(4)) |=> $stable(mask_v));
    // R10
    misaligned_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i[1:0] != 2'b00 && evt_i == '0) |=> ($stable(mask_v) && $stable(stat_v)));
    // R8
    strobe_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == ADDR_W'(8) || addr_i == ADDR_W'(12)) |-> rdata_o == '0);
endmodule

// File: tb/irqsm_regs_tb_top.sv
`timescale 1ns/1ps
module irqsm_regs_tb_top;
    localparam int AW = 4;
    localparam int DW = 32;
    localparam int NS = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          we = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [NS-1:0] evt = '0;
    logic          irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic [NS-1:0] m_stat = '0;
    logic [NS-1:0] m_mask = '1;

    always #2.5 clk = ~clk;

    irqsm_regs #(.ADDR_W(AW), .DATA_W(DW), .N_SRC(NS)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .we_i(we),
        .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .irq_o(irq)
    );

    function automatic logic m_irq();
        return |(m_stat & ~m_mask);
    endfunction

    function automatic logic [DW-1:0] exp_rd(logic [AW-1:0] a);
        if (a[1:0] != 2'b00) return '0;
        case (a[3:2])
            2'd0:    return m_stat;
            2'd1:    return m_mask;
            default: return '0;
        endcase
    endfunction

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_upd(logic w, logic [AW-1:0] a, logic [DW-1:0] d, logic [NS-1:0] e);
        logic ok;
        ok = (a[1:0] == 2'b00);
        if (w && ok && a[3:2] == 2'd0) m_stat = m_stat & ~d[NS-1:0];
        m_stat = m_stat | e;
        if (w && ok && a[3:2] == 2'd2) m_mask = m_mask & ~d[NS-1:0];
        if (w && ok && a[3:2] == 2'd3) m_mask = m_mask | d[NS-1:0];
    endtask

    task automatic step(string tag, logic w, logic [AW-1:0] a, logic [DW-1:0] d, logic [NS-1:0] e);
        @(negedge clk);
        we = w; addr = a; wdata = d; evt = e;
        #1;
        chk({tag, " R9 no change before edge"}, {31'd0, irq}, {31'd0, m_irq()});
        @(posedge clk);
        model_upd(w, a, d, e);
        @(negedge clk);
        we = 1'b0; evt = '0;
        #1;
        chk({tag, " R9 irq after edge"}, {31'd0, irq}, {31'd0, m_irq()});
    endtask

    task automatic rd_chk(string tag, logic [AW-1:0] a);
        @(negedge clk);
        we = 1'b0; evt = '0; addr = a;
        #1;
        chk(tag, rdata, exp_rd(a));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int unsigned sd;
        sd = $urandom(32'h1a2b3c4d);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 irq in reset", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;
        rd_chk("R1 status after reset", 4'h0);
        rd_chk("R1 mask after reset", 4'h4);
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);

        // R2: raise while masked, stays pending, no interrupt
        step("R2 raise masked", 1'b0, 4'h0, '0, 32'h1);
        rd_chk("R2 sticky status", 4'h0);
        // R5: direct mask write ignored
        step("R5 mask write", 1'b1, 4'h4, 32'h0, '0);
        rd_chk("R5 mask unchanged", 4'h4);
        // R6: open bit 0, irq rises
        step("R6 enable bit0", 1'b1, 4'h8, 32'h1, '0);
        rd_chk("R6 mask after enable", 4'h4);
        chk("R6 R9 irq high", {31'd0, irq}, 32'd1);
        // R8: strobes read zero
        rd_chk("R8 enable reads zero", 4'h8);
        rd_chk("R8 disable reads zero", 4'hC);
        // R3: write zero keeps, write one clears
        step("R3 w1c zero", 1'b1, 4'h0, 32'h0, '0);
        rd_chk("R3 status kept", 4'h0);
        step("R3 w1c one", 1'b1, 4'h0, 32'h1, '0);
        rd_chk("R3 status cleared", 4'h0);
        chk("R3 R9 irq low", {31'd0, irq}, 32'd0);
        // R4: collision, set wins
        step("R4 collision", 1'b1, 4'h0, 32'h1, 32'h1);
        rd_chk("R4 status set", 4'h0);
        chk("R4 irq high", {31'd0, irq}, 32'd1);
        // R10: misaligned accesses inert
        step("R10 misaligned disable", 1'b1, 4'hD, 32'hFFFF_FFFF, '0);
        rd_chk("R10 mask unchanged", 4'h4);
        step("R10 misaligned clear", 1'b1, 4'h1, 32'hFFFF_FFFF, '0);
        rd_chk("R10 status unchanged", 4'h1);
        rd_chk("R10 R11 status aligned", 4'h0);
        // R7: close bit 0
        step("R7 disable bit0", 1'b1, 4'hC, 32'h1, '0);
        rd_chk("R7 mask after disable", 4'h4);
        chk("R7 irq low", {31'd0, irq}, 32'd0);
        // R8: strobe registers store nothing
        step("R8 enable upper", 1'b1, 4'h8, 32'hF000_0000, '0);
        rd_chk("R8 enable still zero", 4'h8);
        rd_chk("R11 mask partial", 4'h4);

        // Random phase
        for (int i = 0; i < 800; i++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            logic [NS-1:0] e;
            logic          w;
            a = AW'($urandom % 16);
            if ($urandom % 4 != 0) a[1:0] = 2'b00;
            w = ($urandom % 4 != 0);
            d = ($urandom % 3 == 0) ? (32'h1 << ($urandom % 32)) : $urandom;
            e = ($urandom % 3 == 0) ? NS'(32'h1 << ($urandom % 32)) : '0;
            if (a == 4'h0 && ($urandom % 2 == 1)) e = e | (d & $urandom);
            step("R2 R3 R4 R6 R7 random", w, a, d, e);
            rd_chk("R11 random read", AW'({$urandom % 4, 2'b00}));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule